// File: doc/BRIEF.md
# Page Entry Permission Check and Reference/Change Update

This block takes one leaf page table entry that a table walker has already fetched, together with the kind of access that is being attempted, and decides whether that access may proceed. It computes the read/write/execute rights the entry grants in the current context and reports a fault cause when the access is refused. When the access is allowed, it builds the updated entry with the reference bit set, and with the change bit set as well for a store. If the update altered the entry, the block stores it back through a valid/ready write port.

The rights come from three sources. The first is the entry's own access-authority bits. The second is its privileged marker, weighed against the problem-state bit and against whether the entry belongs to partition-scoped or process-scoped translation. The third is an authority-mask permission set that limits privileged code on ordinary process-scoped pages. There is also an attribute check, so an instruction fetch from a page attributed as non-idempotent I/O is always refused.

For a load or a fetch, write permission is taken out of the reported rights, so a later store returns to this block and sets the change bit. A caller starts a request with a one-cycle `req_valid` pulse and waits for the one-cycle `done` pulse. The results stay on the outputs until the next request finishes.

Top module: `pte_access_guard`

## Requirements
- R1: After reset, `done`, `wr_valid`, `busy`, `fault`, `fault_cause` and `perm` are all zero.
- R2: A fetch (access code 2) from an entry whose attribute field, bits [5:4], equals 2'b10 faults with only cause bit 0 (guarded/no-execute) set, whatever the authority bits say.
- R3: For process-scoped use (`req_partition`=0), an entry with the privileged bit 3 set that is accessed with `req_problem`=1 is granted no rights, so every access to it faults with cause bit 1 (protection).
- R4: With `req_problem`=0 on a process-scoped entry whose bit 3 is clear, the granted rights are the entry's authority bits {bit2 read, bit1 write, bit0 execute} ANDed with `req_mask`, which uses the same bit order.
- R5: In every other case the granted rights are the entry's authority bits alone, with `req_mask` having no effect. This covers partition-scoped use, problem state on a non-privileged entry, and privileged state on a privileged entry.
- R6: When the access needs a right that was not granted (load needs read, store needs write, fetch needs execute; access code 3 counts as a load), the block faults with cause bit 1. Any fault reports `perm`=0 and issues no write.
- R7: A fault on a store (access code 1) also sets cause bit 2.
- R8: On success, the updated entry equals the input entry with bit 8 (reference) set, and also bit 7 (change) for a store. All other bits are unchanged.
- R9: On a successful store, `perm` equals the granted rights. On a successful load or fetch, `perm` is the granted rights with the write bit cleared.
- R10: A write is issued at `req_pte_addr` only when the updated entry differs from the input. `wr_addr` and `wr_data` are held while `wr_ready` is low. `done` pulses for one cycle: two cycles after the `req_valid` edge when no write is needed, otherwise one cycle after the write handshake edge.
- R11: `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start pulse, accepted when not busy |
| req_access | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_problem | input | 1 | Problem-state (user) access |
| req_partition | input | 1 | Entry belongs to partition-scoped translation |
| req_mask | input | 3 | Authority-mask rights {read, write, execute} |
| req_pte | input | PTE_W | Leaf entry as read from memory |
| req_pte_addr | input | ADDR_W | Address the entry was read from |
| busy | output | 1 | A request is in progress |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | PTE_W | Updated entry |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access refused |
| fault_cause | output | 3 | bit0 guarded fetch, bit1 protection, bit2 store |
| perm | output | 3 | Rights to cache {read, write, execute} |

## Verification
A request accepted at a clock edge produces its decision one edge later. When no write is needed, `done` and the results appear at the edge after that, which is the second falling edge after the request. When a write is needed, `wr_valid` rises at that second edge instead, and `done` follows one edge after the handshake. With `wr_ready` held high, that is the third falling edge. The bench drives inputs on falling edges and counts falling edges from each request until `done`. It checks that count against the expected latency, records any handshake seen on the way, and only then compares the held results. The backpressure test also counts stalled cycles before it expects `done`.

// File: rtl/pte_guard_pkg.sv
package pte_guard_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    // entry field positions
    localparam int B_EXEC   = 0;
    localparam int B_WRITE  = 1;
    localparam int B_READ   = 2;
    localparam int B_PRIV   = 3;
    localparam int B_ATT_LO = 4;
    localparam int B_ATT_HI = 5;
    localparam int B_CHG    = 7;
    localparam int B_REF    = 8;
    localparam logic [1:0] ATT_NONIDEM_IO = 2'b10;

    // rights vector positions
    localparam int P_X = 0;
    localparam int P_W = 1;
    localparam int P_R = 2;

    // fault cause positions
    localparam int C_GUARD = 0;
    localparam int C_PROT  = 1;
    localparam int C_STORE = 2;

    function automatic logic [2:0] rights_needed(acc_e a);
        logic [2:0] r;
        r = '0;
        case (a)
            ACC_STORE: r[P_W] = 1'b1;
            ACC_FETCH: r[P_X] = 1'b1;
            default:   r[P_R] = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
    import pte_guard_pkg::*;
(
    input  acc_e       access,
    input  logic       problem,
    input  logic       partition,
    input  logic [2:0] mask,
    input  logic [2:0] authority,
    input  logic       privileged,
    input  logic [1:0] attribute,
    output logic [2:0] granted,
    output logic       fault,
    output logic [2:0] cause
);
    logic [2:0] rights;
    logic [2:0] needed;
    logic       io_fetch;

    always_comb begin
        needed   = rights_needed(access);
        io_fetch = (access == ACC_FETCH) && (attribute == ATT_NONIDEM_IO);

        if (!partition && privileged && problem) begin
            rights = 3'b000;
        end else if (!partition && !privileged && !problem) begin
            rights = authority & mask;
        end else begin
            rights = authority;
        end

        cause = '0;
        if (io_fetch) begin
            cause[C_GUARD] = 1'b1;
        end else if ((needed & ~rights) != 3'b000) begin
            cause[C_PROT] = 1'b1;
        end
        if ((cause != 3'b000) && (access == ACC_STORE)) begin
            cause[C_STORE] = 1'b1;
        end

        fault   = (cause != 3'b000);
        granted = fault ? 3'b000 : rights;
    end
endmodule

// File: rtl/pte_rc_merge.sv
module pte_rc_merge
    import pte_guard_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  acc_e             access,
    input  logic [2:0]       rights_in,
    output logic [PTE_W-1:0] pte_out,
    output logic             changed,
    output logic [2:0]       rights_out
);
    localparam logic [PTE_W-1:0] REF_MASK = PTE_W'(1) << B_REF;
    localparam logic [PTE_W-1:0] CHG_MASK = PTE_W'(1) << B_CHG;

    always_comb begin
        pte_out = pte_in | REF_MASK;
        rights_out = rights_in;
        if (access == ACC_STORE) begin
            pte_out = pte_out | CHG_MASK;
        end else begin
            // keep the page read-only until a store sets the change bit
            rights_out[P_W] = 1'b0;
        end
        changed = (pte_out != pte_in);
    end
endmodule

// File: rtl/pte_access_guard.sv
module pte_access_guard
    import pte_guard_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_access,
    input  logic              req_problem,
    input  logic              req_partition,
    input  logic [2:0]        req_mask,
    input  logic [PTE_W-1:0]  req_pte,
    input  logic [ADDR_W-1:0] req_pte_addr,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTE_W-1:0]  wr_data,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_cause,
    output logic [2:0]        perm
);
    typedef struct packed {
        st_e               st;
        acc_e              acc;
        logic              prob;
        logic              part;
        logic [2:0]        mask;
        logic [PTE_W-1:0]  pte;
        logic [ADDR_W-1:0] addr;
        logic [PTE_W-1:0]  npte;
        logic              wr_valid;
        logic              done;
        logic              fault;
        logic [2:0]        cause;
        logic [2:0]        perm;
    } regs_t;

    regs_t r_q, r_d;

    logic [2:0]       ev_granted;
    logic             ev_fault;
    logic [2:0]       ev_cause;
    logic [PTE_W-1:0] mg_pte;
    logic             mg_changed;
    logic [2:0]       mg_perm;

    pte_perm_eval u_eval (
        .access     (r_q.acc),
        .problem    (r_q.prob),
        .partition  (r_q.part),
        .mask       (r_q.mask),
        .authority  (r_q.pte[B_READ:B_EXEC]),
        .privileged (r_q.pte[B_PRIV]),
        .attribute  (r_q.pte[B_ATT_HI:B_ATT_LO]),
        .granted    (ev_granted),
        .fault      (ev_fault),
        .cause      (ev_cause)
    );

    pte_rc_merge #(.PTE_W(PTE_W)) u_merge (
        .pte_in     (r_q.pte),
        .access     (r_q.acc),
        .rights_in  (ev_granted),
        .pte_out    (mg_pte),
        .changed    (mg_changed),
        .rights_out (mg_perm)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_EVAL;
                    r_d.acc  = acc_e'(req_access);
                    r_d.prob = req_problem;
                    r_d.part = req_partition;
                    r_d.mask = req_mask;
                    r_d.pte  = req_pte;
                    r_d.addr = req_pte_addr;
                end
            end
            ST_EVAL: begin
                r_d.fault = ev_fault;
                r_d.cause = ev_cause;
                r_d.npte  = mg_pte;
                if (ev_fault) begin
                    r_d.perm = 3'b000;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.perm = mg_perm;
                    if (mg_changed) begin
                        r_d.wr_valid = 1'b1;
                        r_d.st       = ST_WRITE;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    r_d.wr_valid = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.st       = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign wr_valid    = r_q.wr_valid;
    assign wr_addr     = r_q.addr;
    assign wr_data     = r_q.npte;
    assign done        = r_q.done;
    assign fault       = r_q.fault;
    assign fault_cause = r_q.cause;
    assign perm        = r_q.perm;

    // R10: write request and payload held under backpressure
    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: every written entry carries the reference bit
    p_ref_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[B_REF]);

    // R8: a store write-back carries the change bit
    p_chg_on_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (r_q.acc == ACC_STORE) |-> wr_data[B_CHG]);

    // R6: a refused access reports no rights
    p_fault_noperm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> perm == 3'b000);

    // R9: a non-store success never reports write permission
    p_no_write_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault && (r_q.acc != ACC_STORE) |-> !perm[P_W]);

    // R2: a guarded-fetch fault carries no protection cause
    p_guard_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault_cause[C_GUARD] |-> !fault_cause[C_PROT] && !fault_cause[C_STORE]);

    // R6: no write is requested while a fault is being reported
    p_no_wr_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !wr_valid);
endmodule

// File: tb/pte_access_guard_test.sv
module pte_access_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_access = 2'd0;
    logic        req_problem = 1'b0;
    logic        req_partition = 1'b0;
    logic [2:0]  req_mask = 3'd0;
    logic [63:0] req_pte = '0;
    logic [63:0] req_pte_addr = '0;
    logic        busy, wr_valid, done, fault;
    logic        wr_ready = 1'b1;
    logic [63:0] wr_addr, wr_data;
    logic [2:0]  fault_cause, perm;

    always #5 clk = ~clk;

    pte_access_guard uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_access(req_access),
        .req_problem(req_problem), .req_partition(req_partition), .req_mask(req_mask),
        .req_pte(req_pte), .req_pte_addr(req_pte_addr), .busy(busy),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .fault(fault), .fault_cause(fault_cause), .perm(perm)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [63:0] HI = 64'h5A3C_0000_0000_0000;

    typedef struct packed {
        logic [1:0]  acc;
        logic        prob;
        logic        part;
        logic [2:0]  amr;
        logic [15:0] pte;
        logic [2:0]  eperm;
        logic        efault;
        logic [2:0]  ecause;
        logic        ewr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 1'b0, 3'b111, 16'h0007, 3'b101, 1'b0, 3'b000, 1'b1}, // R4 R9 load, mask full
        '{2'd1, 1'b0, 1'b0, 3'b111, 16'h0007, 3'b111, 1'b0, 3'b000, 1'b1}, // R8 store sets R and C
        '{2'd1, 1'b0, 1'b0, 3'b111, 16'h0187, 3'b111, 1'b0, 3'b000, 1'b0}, // R10 already R and C
        '{2'd0, 1'b0, 1'b0, 3'b111, 16'h0107, 3'b101, 1'b0, 3'b000, 1'b0}, // R10 load, R already set
        '{2'd2, 1'b0, 1'b0, 3'b111, 16'h0027, 3'b000, 1'b1, 3'b001, 1'b0}, // R2 fetch from I/O page
        '{2'd0, 1'b0, 1'b0, 3'b111, 16'h0027, 3'b101, 1'b0, 3'b000, 1'b1}, // R2 load from I/O page ok
        '{2'd0, 1'b1, 1'b0, 3'b111, 16'h000F, 3'b000, 1'b1, 3'b010, 1'b0}, // R3 user on priv page
        '{2'd0, 1'b1, 1'b1, 3'b000, 16'h000F, 3'b101, 1'b0, 3'b000, 1'b1}, // R5 partition-scoped
        '{2'd0, 1'b0, 1'b0, 3'b011, 16'h0007, 3'b000, 1'b1, 3'b010, 1'b0}, // R4 mask removes read
        '{2'd1, 1'b0, 1'b0, 3'b110, 16'h0007, 3'b110, 1'b0, 3'b000, 1'b1}, // R4 mask removes exec
        '{2'd1, 1'b0, 1'b0, 3'b111, 16'h0005, 3'b000, 1'b1, 3'b110, 1'b0}, // R6 R7 store, no write right
        '{2'd2, 1'b1, 1'b0, 3'b000, 16'h0001, 3'b001, 1'b0, 3'b000, 1'b1}, // R5 user fetch ignores mask
        '{2'd2, 1'b0, 1'b0, 3'b000, 16'h000D, 3'b101, 1'b0, 3'b000, 1'b1}, // R5 priv on priv page
        '{2'd1, 1'b1, 1'b0, 3'b111, 16'h000F, 3'b000, 1'b1, 3'b110, 1'b0}  // R3 R7 user store priv page
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // issue one request; returns falling-edge count to done and write observations
    task automatic issue(input logic [1:0] acc, input logic prob, input logic part,
                         input logic [2:0] amr, input logic [63:0] pte, input logic [63:0] addr,
                         output int lat, output bit wrote, output logic [63:0] wdat,
                         output logic [63:0] wadr);
        @(negedge clk);
        req_access = acc; req_problem = prob; req_partition = part;
        req_mask = amr; req_pte = pte; req_pte_addr = addr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; wrote = 1'b0; wdat = '0; wadr = '0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (wr_valid && wr_ready) begin
                wrote = 1'b1; wdat = wr_data; wadr = wr_addr;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        bit wrote;
        logic [63:0] wdat, wadr, exp_pte;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && wr_valid == 0 && busy == 0, "R1 handshake idle",
            {busy, wr_valid, done}, 0);
        chk(fault == 0 && fault_cause == 0 && perm == 0, "R1 results cleared",
            {fault, fault_cause, perm}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            exp_pte = (HI | 64'(v.pte)) | 64'h100 | ((v.acc == 2'd1) ? 64'h80 : 64'h0);
            issue(v.acc, v.prob, v.part, v.amr, HI | 64'(v.pte), 64'h1000 + 64'(i * 8),
                  lat, wrote, wdat, wadr);
            chk(lat == (v.ewr ? 3 : 2), $sformatf("R10 latency vec %0d", i), lat, v.ewr ? 3 : 2);
            chk(fault == v.efault, $sformatf("R6 fault vec %0d", i), fault, v.efault);
            chk(fault_cause == v.ecause, $sformatf("R2/R3/R7 cause vec %0d", i), fault_cause, v.ecause);
            chk(perm == v.eperm, $sformatf("R4/R5/R9 perm vec %0d", i), perm, v.eperm);
            chk(wrote == v.ewr, $sformatf("R10 write issued vec %0d", i), wrote, v.ewr);
            if (v.ewr && wrote) begin
                chk(wdat == exp_pte, $sformatf("R8 entry vec %0d", i), wdat, exp_pte);
                chk(wadr == 64'h1000 + 64'(i * 8), $sformatf("R10 addr vec %0d", i), wadr,
                    64'h1000 + 64'(i * 8));
            end
        end

        // R10 backpressure, R11 request while busy
        wr_ready = 1'b0;
        @(negedge clk);
        req_access = 2'd1; req_problem = 1'b0; req_partition = 1'b0; req_mask = 3'b111;
        req_pte = HI | 64'h7; req_pte_addr = 64'h2000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(wr_valid == 1 && done == 0, "R10 write requested", {wr_valid, done}, 2'b10);
        // R11: this request arrives while busy and must be ignored
        req_access = 2'd0; req_pte = 64'h3; req_pte_addr = 64'h3000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(wr_valid == 1 && done == 0, "R10 stalled cycle 2", {wr_valid, done}, 2'b10);
        chk(wr_data == (HI | 64'h187) && wr_addr == 64'h2000, "R10 payload held",
            wr_data, HI | 64'h187);
        @(negedge clk);
        chk(wr_valid == 1 && done == 0, "R10 stalled cycle 3", {wr_valid, done}, 2'b10);
        wr_ready = 1'b1;
        @(negedge clk);
        chk(done == 1 && wr_valid == 0, "R10 done after handshake", {wr_valid, done}, 2'b01);
        chk(perm == 3'b111 && fault == 0, "R9 store keeps write right", perm, 3'b111);
        begin
            bit extra;
            extra = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done || wr_valid || busy) extra = 1'b1;
            end
            chk(!extra, "R11 busy request ignored", extra, 0);
        end
        chk(perm == 3'b111 && wr_data == (HI | 64'h187), "R11 results untouched", perm, 3'b111);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule